// File: doc/BRIEF.md
# DMA Request Screening Queue

This block stands between a host that issues DMA transfer requests and the engine that carries them out. Each request carries a source address, a destination address, a 16-bit byte count, a transfer-mode code, an addressing-mode code and a width code. On the cycle the request is presented, the block decides whether the request is legal and returns a status code combinationally. A legal request is written into an in-order queue that the downstream engine drains with a pop strobe.

The block rejects a request on the fields alone: a width code out of range, an invalid mode or addressing code. It also rejects a request on combinations of fields: a burst width on a side whose address is held fixed, or a swapping or reversing mode with a byte count that is not a whole number of words. Every reason for rejection has its own status code. When more than one rule fails, one fixed precedence decides which code is reported. An occupancy count tells the host how many requests are waiting. Until an init strobe has been seen after reset, every request is refused with a generic fail code.

Top module: `dma_req_screen`

## Requirements
- R1: Until `init_strobe` has been high on a clock edge after reset, every request returns status 1 (fail) and nothing is queued. A request presented on the same cycle as the first strobe also returns 1.
- R2: Status encoding: 0 accepted, 1 fail, 2 bad width, 3 bad length, 4 bad mode, 5 bad addressing, 6 queue full. `stat_valid` equals `req_valid` in the same cycle, and `stat_code` is valid in that cycle.
- R3: A width code of 16 or above returns 2. Burst-destination codes (9, 10, 11, 15) with addressing code 1 or 3 (destination fixed) return 2. Burst-source codes (12 to 15) with addressing code 2 or 3 (source fixed) return 2.
- R4: `req_len` is a byte count, and 0 means 65536. With mode codes 2 (byte swap) and 3 (reverse), a count with `req_len[1:0]` not zero returns 3. Modes 0 and 1 accept any count, including 1 and 0.
- R5: A mode code of 4 or above returns 4.
- R6: Addressing code 3 (both sides fixed) with a width that is not rejected returns 5.
- R7: Precedence when several rules fail: fail (R1), then width, then length, then mode, then addressing, then queue full.
- R8: The queue holds DEPTH (16) requests. A request that would otherwise be accepted while `pend_count` equals DEPTH returns 6 and is dropped, even if `q_pop` removes an entry in the same cycle.
- R9: Accepted requests appear on the `q_*` outputs in arrival order with every field unchanged. `q_valid` is high exactly when `pend_count` is non-zero, and `q_pop` with `q_valid` high removes the head entry.
- R10: `pend_count` is 0 after reset. It rises by one on an accepted request, falls by one on a pop of a non-empty queue, and stays the same when both happen in the same cycle. A pop of an empty queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| init_strobe | input | 1 | Enables request acceptance from the next cycle on |
| req_valid | input | 1 | A request is presented this cycle |
| req_src | input | ADDR_W | Source start address |
| req_dst | input | ADDR_W | Destination start address |
| req_len | input | 16 | Byte count, 0 means 65536 |
| req_mode | input | 3 | Transfer mode: 0 copy and clear source, 1 copy, 2 copy with byte swap, 3 copy reversed |
| req_amode | input | 2 | Addressing: 0 inc/inc, 1 inc src/fixed dst, 2 fixed src/inc dst, 3 fixed/fixed |
| req_wcode | input | 5 | Width pairing code, 0 to 15 legal |
| stat_valid | output | 1 | Status qualifier, follows req_valid |
| stat_code | output | 3 | Status of the presented request |
| q_valid | output | 1 | Queue head holds a request |
| q_pop | input | 1 | Engine takes the head entry |
| q_src | output | ADDR_W | Head source address |
| q_dst | output | ADDR_W | Head destination address |
| q_len | output | 16 | Head byte count |
| q_mode | output | 3 | Head transfer mode |
| q_amode | output | 2 | Head addressing mode |
| q_wcode | output | 5 | Head width code |
| pend_count | output | $clog2(DEPTH+1) | Number of queued requests |

## Verification
Two functions can fall in the same cycle: the engine can pop the queue while a new request is being judged and pushed. The bench provokes this with the queue partly filled, where the count must hold steady and the arrival order must be kept. It also provokes it with the queue full, where the request must still be refused as full while the count drops by one. A scoreboard queue holds the expected entries and compares each popped head in full. A cycle-exact occupancy model checks `pend_count` and `q_valid` after every edge.

// File: rtl/dma_req_screen_pkg.sv
package dma_req_screen_pkg;

  localparam int LEN_W   = 16;
  localparam int MODE_W  = 3;
  localparam int AMODE_W = 2;
  localparam int WCODE_W = 5;
  localparam int ALIGN_LSB = 2;  // word alignment for swap / reverse

  typedef enum logic [2:0] {
    ST_OK        = 3'd0,
    ST_FAIL      = 3'd1,
    ST_BAD_WIDTH = 3'd2,
    ST_BAD_LEN   = 3'd3,
    ST_BAD_MODE  = 3'd4,
    ST_BAD_AMODE = 3'd5,
    ST_FULL      = 3'd6
  } req_status_e;

  localparam logic [MODE_W-1:0]  MODE_SWAP   = MODE_W'(2);
  localparam logic [MODE_W-1:0]  MODE_REV    = MODE_W'(3);
  localparam logic [MODE_W-1:0]  MODE_LAST   = MODE_W'(3);
  localparam logic [AMODE_W-1:0] AM_INC_FIX  = AMODE_W'(1);
  localparam logic [AMODE_W-1:0] AM_FIX_INC  = AMODE_W'(2);
  localparam logic [AMODE_W-1:0] AM_FIX_FIX  = AMODE_W'(3);
  localparam logic [WCODE_W-1:0] WC_LAST     = WCODE_W'(15);
  localparam logic [WCODE_W-1:0] WC_BDST_LO  = WCODE_W'(9);
  localparam logic [WCODE_W-1:0] WC_BDST_HI  = WCODE_W'(11);
  localparam logic [WCODE_W-1:0] WC_BSRC_LO  = WCODE_W'(12);

  // destination side is a burst
  function automatic logic wc_burst_dst(input logic [WCODE_W-1:0] wc);
    return ((wc >= WC_BDST_LO) && (wc <= WC_BDST_HI)) || (wc == WC_LAST);
  endfunction

  // source side is a burst
  function automatic logic wc_burst_src(input logic [WCODE_W-1:0] wc);
    return (wc >= WC_BSRC_LO) && (wc <= WC_LAST);
  endfunction

endpackage

// File: rtl/dma_req_rules.sv
module dma_req_rules
  import dma_req_screen_pkg::*;
(
  input  logic               enabled,
  input  logic               queue_full,
  input  logic [LEN_W-1:0]   len,
  input  logic [MODE_W-1:0]  mode,
  input  logic [AMODE_W-1:0] amode,
  input  logic [WCODE_W-1:0] wcode,
  output req_status_e        status
);

  logic dst_fixed, src_fixed;
  logic width_bad, len_bad, mode_bad, amode_bad;

  always_comb begin
    dst_fixed = (amode == AM_INC_FIX) || (amode == AM_FIX_FIX);
    src_fixed = (amode == AM_FIX_INC) || (amode == AM_FIX_FIX);
    // R3: range plus burst-against-fixed-address rules
    width_bad = (wcode > WC_LAST)
              || (wc_burst_dst(wcode) && dst_fixed)
              || (wc_burst_src(wcode) && src_fixed);
    // R4: swap / reverse need whole words; 0 encodes 65536 and is aligned
    len_bad   = ((mode == MODE_SWAP) || (mode == MODE_REV))
              && (len[ALIGN_LSB-1:0] != '0);
    // R5
    mode_bad  = mode > MODE_LAST;
    // R6
    amode_bad = amode == AM_FIX_FIX;
  end

  // R7: fixed precedence chain
  always_comb begin
    if (!enabled)        status = ST_FAIL;
    else if (width_bad)  status = ST_BAD_WIDTH;
    else if (len_bad)    status = ST_BAD_LEN;
    else if (mode_bad)   status = ST_BAD_MODE;
    else if (amode_bad)  status = ST_BAD_AMODE;
    else if (queue_full) status = ST_FULL;
    else                 status = ST_OK;
  end

endmodule

// File: rtl/dma_req_fifo.sv
module dma_req_fifo #(
  parameter int DATA_W = 64,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  count,
  output logic              full
);

  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  slot_we;
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              push_do, pop_do;

  assign full    = cnt_q == CNT_W'(DEPTH);
  assign push_do = push && !full;
  assign pop_do  = pop && (cnt_q != '0);

  // next state
  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_do)
      wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    if (pop_do)
      rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    case ({push_do, pop_do})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // per-slot write enables
  for (genvar i = 0; i < DEPTH; i++) begin : g_we
    assign slot_we[i] = push_do && (wr_ptr_q == PTR_W'(i));
  end

  // storage, no reset
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++)
      if (slot_we[i]) slot_q[i] <= wdata;
  end

  assign rdata = slot_q[rd_ptr_q];
  assign count = cnt_q;

  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));

  a_r10_push_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  a_r10_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && (cnt_q == '0)) |=> (cnt_q == '0));

  a_r10_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && pop && (cnt_q != '0)) |=> $stable(cnt_q));

endmodule

// File: rtl/dma_req_screen.sv
module dma_req_screen
  import dma_req_screen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_strobe,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_src,
  input  logic [ADDR_W-1:0]  req_dst,
  input  logic [LEN_W-1:0]   req_len,
  input  logic [MODE_W-1:0]  req_mode,
  input  logic [AMODE_W-1:0] req_amode,
  input  logic [WCODE_W-1:0] req_wcode,
  output logic               stat_valid,
  output logic [2:0]         stat_code,
  output logic               q_valid,
  input  logic               q_pop,
  output logic [ADDR_W-1:0]  q_src,
  output logic [ADDR_W-1:0]  q_dst,
  output logic [LEN_W-1:0]   q_len,
  output logic [MODE_W-1:0]  q_mode,
  output logic [AMODE_W-1:0] q_amode,
  output logic [WCODE_W-1:0] q_wcode,
  output logic [CNT_W-1:0]   pend_count
);

  localparam int ENTRY_W = 2 * ADDR_W + LEN_W + MODE_W + AMODE_W + WCODE_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // R1: enable latch
  logic init_q, init_d;
  always_comb init_d = init_q | init_strobe;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) init_q <= 1'b0;
    else            init_q <= init_d;
  end

  // checks
  req_status_e status;
  logic        q_full;
  logic        accept;

  dma_req_rules u_rules (
    .enabled    (init_q),
    .queue_full (q_full),
    .len        (req_len),
    .mode       (req_mode),
    .amode      (req_amode),
    .wcode      (req_wcode),
    .status     (status)
  );

  assign accept     = req_valid && (status == ST_OK);
  assign stat_valid = req_valid;
  assign stat_code  = status;

  // queue
  logic [ENTRY_W-1:0] push_word, head_word;

  assign push_word = {req_src, req_dst, req_len, req_mode, req_amode, req_wcode};

  dma_req_fifo #(
    .DATA_W (ENTRY_W),
    .DEPTH  (DEPTH)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_int_n),
    .push  (accept),
    .wdata (push_word),
    .pop   (q_pop),
    .rdata (head_word),
    .count (pend_count),
    .full  (q_full)
  );

  assign {q_src, q_dst, q_len, q_mode, q_amode, q_wcode} = head_word;
  assign q_valid = pend_count != '0;

  a_r1_empty_before_init: assert property (@(posedge clk) disable iff (!rst_int_n)
    !init_q |-> (pend_count == '0));

  a_r8_full_refused: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && (pend_count == CNT_W'(DEPTH))) |-> (stat_code != ST_OK));

  a_r10_accept_grows: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && (stat_code == ST_OK) && !q_pop)
      |=> (pend_count == CNT_W'($past(pend_count) + 1'b1)));

  a_r9_head_held: assert property (@(posedge clk) disable iff (!rst_int_n)
    (q_valid && !q_pop) |=> $stable(head_word));

endmodule

// File: tb/dma_req_screen_bench.sv
module dma_req_screen_bench;
  import dma_req_screen_pkg::*;

  localparam int AW    = 32;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  typedef struct packed {
    logic [AW-1:0] s;
    logic [AW-1:0] d;
    logic [15:0]   l;
    logic [2:0]    m;
    logic [1:0]    a;
    logic [4:0]    w;
  } item_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rst_n, init_strobe, req_valid, q_pop;
  logic [AW-1:0] req_src, req_dst;
  logic [15:0]   req_len;
  logic [2:0]    req_mode;
  logic [1:0]    req_amode;
  logic [4:0]    req_wcode;
  logic          stat_valid, q_valid;
  logic [2:0]    stat_code;
  logic [AW-1:0] q_src, q_dst;
  logic [15:0]   q_len;
  logic [2:0]    q_mode;
  logic [1:0]    q_amode;
  logic [4:0]    q_wcode;
  logic [CW-1:0] pend_count;

  dma_req_screen #(.ADDR_W(AW), .DEPTH(DEPTH)) u_dma_req_screen (
    .clk, .rst_n, .init_strobe, .req_valid, .req_src, .req_dst, .req_len,
    .req_mode, .req_amode, .req_wcode, .stat_valid, .stat_code, .q_valid,
    .q_pop, .q_src, .q_dst, .q_len, .q_mode, .q_amode, .q_wcode, .pend_count
  );

  int    nchk = 0;
  int    nbad = 0;
  int    exp_cnt = 0;
  bit    ini_next = 0;
  item_t sb_q[$];

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic item_t mk(input logic [AW-1:0] s, input logic [15:0] l,
                               input logic [2:0] m, input logic [1:0] a,
                               input logic [4:0] w);
    item_t it;
    it.s = s; it.d = s ^ 32'hA5A5_0000; it.l = l; it.m = m; it.a = a; it.w = w;
    return it;
  endfunction

  // driver: one cycle, optional request and pop, expected status given
  task automatic step(input bit v, input item_t it, input int exp_st,
                      input bit pop, input string tag);
    bit popd;
    @(negedge clk);
    init_strobe = ini_next;
    ini_next    = 0;
    req_valid   = v;
    {req_src, req_dst, req_len, req_mode, req_amode, req_wcode} = it;
    q_pop       = pop;
    #2;
    if (v) begin
      chk({tag, " status"}, 128'(stat_code), 128'(exp_st));
      chk("R2 stat_valid", 128'(stat_valid), 128'(1));
      if (exp_st == 0) sb_q.push_back(it);
    end
    popd    = pop && (exp_cnt > 0);
    exp_cnt = exp_cnt + ((v && exp_st == 0) ? 1 : 0) - (popd ? 1 : 0);
    @(posedge clk);
    #1;
    req_valid   = 0;
    q_pop       = 0;
    init_strobe = 0;
    chk({tag, " R10 pend_count"}, 128'(pend_count), 128'(exp_cnt));
    chk("R9 q_valid", 128'(q_valid), 128'(exp_cnt != 0));
  endtask

  // monitor: compare each popped head with the scoreboard
  always @(negedge clk) begin
    #3;
    if (q_pop && q_valid) begin
      if (sb_q.size() == 0) begin
        chk("R9 pop with empty scoreboard", 128'(1), 128'(0));
      end else begin
        chk("R9 head entry", 128'({q_src, q_dst, q_len, q_mode, q_amode, q_wcode}),
            128'(sb_q[0]));
        void'(sb_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", nchk + 1, nbad);
    $finish;
  end

  initial begin
    item_t z;
    z = mk(32'h100, 16'd4, 3'd1, 2'd0, 5'd0);
    rst_n = 0; init_strobe = 0; req_valid = 0; q_pop = 0;
    {req_src, req_dst, req_len, req_mode, req_amode, req_wcode} = z;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;
    chk("R10 reset pend_count", 128'(pend_count), 128'(0));
    chk("R9 reset q_valid", 128'(q_valid), 128'(0));
    chk("R2 reset stat_valid", 128'(stat_valid), 128'(0));

    // R1: before init, and on the init cycle itself
    step(1, mk(32'h1000, 16'd8, 3'd1, 2'd0, 5'd0), 1, 0, "R1 pre-init");
    ini_next = 1;
    step(1, mk(32'h1004, 16'd8, 3'd1, 2'd0, 5'd0), 1, 0, "R1 same cycle as init");

    // R4: length edges in plain modes
    step(1, mk(32'h2000, 16'd1, 3'd1, 2'd0, 5'd0), 0, 0, "R4 len 1");
    step(1, mk(32'h2004, 16'd0, 3'd0, 2'd0, 5'd8), 0, 0, "R4 len 65536");

    // R3: width rules
    step(1, mk(32'h3000, 16'd4, 3'd1, 2'd0, 5'd16), 2, 0, "R3 wcode 16");
    step(1, mk(32'h3004, 16'd4, 3'd1, 2'd0, 5'd31), 2, 0, "R3 wcode 31");
    step(1, mk(32'h3008, 16'd4, 3'd1, 2'd1, 5'd9),  2, 0, "R3 burst dst fixed dst");
    step(1, mk(32'h300C, 16'd4, 3'd1, 2'd3, 5'd15), 2, 0, "R3 burst both fixed both");
    step(1, mk(32'h3010, 16'd4, 3'd1, 2'd2, 5'd12), 2, 0, "R3 burst src fixed src");
    step(1, mk(32'h3014, 16'd4, 3'd1, 2'd1, 5'd12), 0, 0, "R3 burst src fixed dst ok");
    step(1, mk(32'h3018, 16'd4, 3'd1, 2'd2, 5'd11), 0, 0, "R3 burst dst fixed src ok");

    // R4: alignment in swap / reverse
    step(1, mk(32'h4000, 16'd6, 3'd2, 2'd0, 5'd0), 3, 0, "R4 swap len 6");
    step(1, mk(32'h4004, 16'd5, 3'd3, 2'd0, 5'd0), 3, 0, "R4 reverse len 5");
    step(1, mk(32'h4008, 16'd8, 3'd3, 2'd0, 5'd0), 0, 0, "R4 reverse len 8");
    step(1, mk(32'h400C, 16'd0, 3'd2, 2'd0, 5'd4), 0, 0, "R4 swap len 65536");

    // R5, R6
    step(1, mk(32'h5000, 16'd4, 3'd4, 2'd0, 5'd0), 4, 0, "R5 mode 4");
    step(1, mk(32'h5004, 16'd4, 3'd7, 2'd0, 5'd0), 4, 0, "R5 mode 7");
    step(1, mk(32'h6000, 16'd4, 3'd1, 2'd3, 5'd0), 5, 0, "R6 fixed to fixed");

    // R7: precedence
    step(1, mk(32'h7000, 16'd1, 3'd2, 2'd0, 5'd16), 2, 0, "R7 width over length");
    step(1, mk(32'h7004, 16'd1, 3'd2, 2'd3, 5'd0),  3, 0, "R7 length over addressing");
    step(1, mk(32'h7008, 16'd4, 3'd5, 2'd3, 5'd0),  4, 0, "R7 mode over addressing");

    // R10: push and pop together with entries pending (count 6)
    step(1, mk(32'h8000, 16'd12, 3'd0, 2'd0, 5'd1), 0, 1, "R10 push with pop");

    // drain, then one pop on empty
    repeat (6) step(0, z, 0, 1, "R9 drain");
    step(0, z, 0, 1, "R10 pop on empty");

    // R8: fill, then full cases
    for (int i = 0; i < DEPTH; i++)
      step(1, mk(32'h9000 + 32'(i * 16), 16'(4 + i), 3'(i % 2), 2'd0, 5'(i % 9)), 0, 0, "R8 fill");
    step(1, mk(32'hA000, 16'd4, 3'd1, 2'd0, 5'd0), 6, 0, "R8 full");
    step(1, mk(32'hA004, 16'd4, 3'd1, 2'd3, 5'd0), 5, 0, "R7 addressing over full");
    step(1, mk(32'hA008, 16'd4, 3'd1, 2'd0, 5'd0), 6, 1, "R8 full with pop");
    step(1, mk(32'hA00C, 16'd4, 3'd1, 2'd0, 5'd0), 0, 1, "R10 push with pop at 15");
    step(1, mk(32'hA010, 16'd4, 3'd1, 2'd0, 5'd0), 0, 0, "R8 refill");
    for (int i = 0; i < DEPTH; i++) step(0, z, 0, 1, "R9 final drain");
    step(0, z, 0, 0, "R10 idle");
    chk("R9 scoreboard empty", 128'(sb_q.size()), 128'(0));

    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule